// File: doc/BRIEF.md
# Remote GPIO Serial Bridge

This block is the controller-side end of a three-wire link to a companion FPGA. The FPGA supplies a link clock of at most 25 MHz, sends one serial data line into the block and reads one serial data line back from it. Each direction moves a 32-bit frame, least significant bit first, with both lines shifting on the rising link-clock edge. A 5-bit bit counter wrapping from 31 to 0 marks the frame boundary.

The received frame drives twenty even-numbered external pins and four remote input bits. All twenty pins stay at high impedance unless the frame's top nibble carries the activation code 1010. The outgoing frame returns the twenty odd-numbered pin values and four remote output bits, topped by the same code.

The link clock and data are synchronised into the system clock domain and edges are found there. The system clock must therefore run at four or more times the link clock.

Top module: `rgpio_bridge`

## Requirements
- R1: While reset is held, and after its release until a frame completes, `ext_oe_o` is all zero, `ext_drv_o` and `aux_rx_o` are zero, and `lnk_dout` is low.
- R2: Received data is shifted in LSB first. After the 32nd rising link-clock edge of a frame, bit k of that frame (k = 0 to 19) appears on `ext_drv_o[k]`.
- R3: When the received bits 31:28 equal 1010, every bit of `ext_oe_o` is 1. For any other value every bit is 0, and `aux_rx_o` reads zero.
- R4: With a valid code, received bits 23:20 appear on `aux_rx_o[3:0]`.
- R5: Received bits 27:24 are ignored. Setting them changes neither the pin values, the enables nor `aux_rx_o`.
- R6: `ext_drv_o`, `ext_oe_o` and `aux_rx_o` change only at a frame boundary. A partly received frame never shows on them.
- R7: The sent frame is LSB first. It has `ext_smp_i` in bits 19:0, `aux_tx_i` in bits 23:20, zeros in bits 27:24 and 1010 in bits 31:28.
- R8: The first frame sent after reset is all zeros.
- R9: The sent frame samples `ext_smp_i` and `aux_tx_i` at the boundary that begins it. Later changes to those inputs only show in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the link clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lnk_clk | input | 1 | Link clock from the FPGA |
| lnk_din | input | 1 | Serial data from the FPGA |
| lnk_dout | output | 1 | Serial data to the FPGA |
| ext_drv_o | output | 20 | Values for the even-numbered external pins |
| ext_oe_o | output | 20 | Output enables for those pins (0 = high impedance) |
| ext_smp_i | input | 20 | Sampled odd-numbered external pins |
| aux_rx_o | output | 4 | Remote input bits received from the FPGA |
| aux_tx_i | input | 4 | Remote output bits sent to the FPGA |

## Verification
On the edge that ends a frame, the block latches the completed receive frame and also loads a fresh transmit frame. Both actions happen in the same system cycle. The bench provokes this by changing `ext_smp_i` and `aux_tx_i` halfway through a frame while a new receive word is arriving. It then judges two things: the transmit word in flight must still carry the values from the earlier boundary, and the pins must switch only once the last receive bit has landed. A scoreboard queue holds each expected transmit word and compares it with the bits gathered from `lnk_dout` over the next frame.

// File: rtl/rgpio_pkg.sv
package rgpio_pkg;
   localparam int          FRAME_W  = 32;
   localparam int          PIN_W    = 20;
   localparam int          AUX_W    = 4;
   localparam int          RSV_W    = 4;
   localparam int          CODE_W   = 4;
   localparam logic [3:0]  ACT_CODE = 4'b1010;
endpackage

// File: rtl/rgpio_sync_edge.sv
module rgpio_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lnk_clk_i,
   input  logic lnk_dat_i,
   output logic rise_o,
   output logic dat_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rgpio_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] clk_sh;
   logic [STAGES-1:0] dat_sh;
   logic              clk_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_sh   <= '0;
         dat_sh   <= '0;
         clk_prev <= 1'b0;
      end else begin
         clk_sh   <= {clk_sh[STAGES-2:0], lnk_clk_i};
         dat_sh   <= {dat_sh[STAGES-2:0], lnk_dat_i};
         clk_prev <= clk_sh[STAGES-1];
      end
   end

   assign rise_o = clk_sh[STAGES-1] & ~clk_prev;
   assign dat_o  = dat_sh[STAGES-1];

   // R2: a detected rise is a single-cycle pulse
   a_r2_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
endmodule

// File: rtl/rgpio_rx.sv
module rgpio_rx #(
   parameter int FRAME_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rise_i,
   input  logic               din_i,
   output logic               frame_end_o,
   output logic [FRAME_W-1:0] hold_o
);
   localparam int CNT_W = $clog2(FRAME_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

   logic [CNT_W-1:0]   cnt;
   logic [FRAME_W-1:0] sr;
   logic [FRAME_W-1:0] nxt_sr;

   assign nxt_sr      = {din_i, sr[FRAME_W-1:1]};
   assign frame_end_o = rise_i && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         sr     <= '0;
         hold_o <= '0;
      end else if (rise_i) begin
         sr  <= nxt_sr;
         cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
         if (cnt == LAST) hold_o <= nxt_sr;
      end
   end

   // R2: the bit counter advances by one on every link edge within a frame
   a_r2_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_i && cnt != LAST) |=> cnt == $past(cnt) + 1'b1);
   // R6: the holding register moves only right after a frame boundary
   a_r6_hold_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_end_o |=> $stable(hold_o));
endmodule

// File: rtl/rgpio_tx.sv
module rgpio_tx #(
   parameter int         FRAME_W  = 32,
   parameter int         CODE_W   = 4,
   parameter logic [3:0] ACT_CODE = 4'b1010
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rise_i,
   input  logic               load_i,
   input  logic [FRAME_W-1:0] frame_i,
   output logic               dout_o
);
   logic [FRAME_W-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sr <= '0;
      else if (load_i) sr <= frame_i;
      else if (rise_i) sr <= {1'b0, sr[FRAME_W-1:1]};
   end

   assign dout_o = sr[0];

   // R7: a frame loaded at the boundary carries the activation code on top
   a_r7_code_loaded: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> sr[FRAME_W-1 -: CODE_W] == ACT_CODE[CODE_W-1:0]);
endmodule

// File: rtl/rgpio_bridge.sv
module rgpio_bridge
   import rgpio_pkg::*;
#(
   parameter int PIN_N       = PIN_W,
   parameter int AUX_N       = AUX_W,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lnk_clk,
   input  logic             lnk_din,
   output logic             lnk_dout,
   output logic [PIN_N-1:0] ext_drv_o,
   output logic [PIN_N-1:0] ext_oe_o,
   input  logic [PIN_N-1:0] ext_smp_i,
   output logic [AUX_N-1:0] aux_rx_o,
   input  logic [AUX_N-1:0] aux_tx_i
);
   localparam int AUX_LO  = PIN_N;
   localparam int CODE_LO = FRAME_W - CODE_W;
   localparam int RSV_N   = FRAME_W - PIN_N - AUX_N - CODE_W;

   generate
      if (RSV_N != RSV_W) begin : g_bad_layout
         $error("rgpio_bridge: pin, aux, reserved and code fields must fill the frame");
      end
   endgenerate

   logic               rise;
   logic               din_s;
   logic               frame_end;
   logic [FRAME_W-1:0] hold;
   logic [FRAME_W-1:0] tx_frame;
   logic               code_ok;

   rgpio_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .lnk_clk_i(lnk_clk), .lnk_dat_i(lnk_din),
      .rise_o(rise), .dat_o(din_s));

   rgpio_rx #(.FRAME_W(FRAME_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .rise_i(rise), .din_i(din_s),
      .frame_end_o(frame_end), .hold_o(hold));

   assign tx_frame = {ACT_CODE[CODE_W-1:0], {RSV_N{1'b0}}, aux_tx_i, ext_smp_i};

   rgpio_tx #(.FRAME_W(FRAME_W), .CODE_W(CODE_W), .ACT_CODE(ACT_CODE)) u_tx (
      .clk(clk), .rst_n(rst_n), .rise_i(rise), .load_i(frame_end),
      .frame_i(tx_frame), .dout_o(lnk_dout));

   assign code_ok = (hold[CODE_LO +: CODE_W] == ACT_CODE[CODE_W-1:0]);

   generate
      for (genvar g = 0; g < PIN_N; g++) begin : g_pin
         assign ext_drv_o[g] = hold[g];
         assign ext_oe_o[g]  = code_ok;
      end
   endgenerate

   assign aux_rx_o = code_ok ? hold[AUX_LO +: AUX_N] : '0;

   // R3: the pin enables switch as one group
   a_r3_oe_all_or_none: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(ext_oe_o) == 0) || ($countones(ext_oe_o) == PIN_N));
   // R3: no remote input value is shown while the pins are released
   a_r3_aux_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_oe_o == '0) |-> (aux_rx_o == '0));
   // R6: no output moves except in the cycle after a frame boundary
   a_r6_pins_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_end |=> ($stable(ext_drv_o) && $stable(ext_oe_o) && $stable(aux_rx_o)));
endmodule

// File: tb/rgpio_bridge_test.sv
module rgpio_bridge_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lnk_clk = 1'b0;
   logic        lnk_din = 1'b0;
   logic        lnk_dout;
   logic [19:0] ext_drv_o;
   logic [19:0] ext_oe_o;
   logic [19:0] ext_smp_i = '0;
   logic [3:0]  aux_rx_o;
   logic [3:0]  aux_tx_i = '0;

   int          n_chk = 0;
   int          n_fail = 0;
   bit          done = 1'b0;
   logic [31:0] exp_q[$];
   logic [31:0] got;

   always #4 clk = ~clk;

   rgpio_bridge uut (
      .clk(clk), .rst_n(rst_n), .lnk_clk(lnk_clk), .lnk_din(lnk_din),
      .lnk_dout(lnk_dout), .ext_drv_o(ext_drv_o), .ext_oe_o(ext_oe_o),
      .ext_smp_i(ext_smp_i), .aux_rx_o(aux_rx_o), .aux_tx_i(aux_tx_i));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] tx_word(input logic [19:0] p, input logic [3:0] a);
      return {4'b1010, 4'b0000, a, p};
   endfunction

   // one link bit: data set in the low phase, sent bit read just before the rise
   task automatic send_bits(input logic [31:0] w, input int lo, input int hi);
      for (int i = lo; i <= hi; i++) begin
         @(negedge clk);
         lnk_clk = 1'b0;
         lnk_din = w[i];
         repeat (4) @(negedge clk);
         got[i]  = lnk_dout;
         lnk_clk = 1'b1;
         repeat (3) @(negedge clk);
      end
   endtask

   // monitor side: compare the gathered word, then queue the next expected one
   task automatic frame_done(input string req);
      logic [31:0] e;
      repeat (2) @(negedge clk);
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 32'hxxxx_xxxx;
      check(req, got, e);
      exp_q.push_back(tx_word(ext_smp_i, aux_tx_i));
   endtask

   task automatic send_frame(input logic [31:0] w, input string req);
      send_bits(w, 0, 31);
      frame_done(req);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 oe", {12'd0, ext_oe_o}, 32'd0);
      check("R1 drv", {12'd0, ext_drv_o}, 32'd0);
      check("R1 aux", {28'd0, aux_rx_o}, 32'd0);
      check("R1 dout", {31'd0, lnk_dout}, 32'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 oe after release", {12'd0, ext_oe_o}, 32'd0);
      exp_q.push_back(32'd0);   // R8: first sent frame is all zero

      ext_smp_i = 20'h12345;
      aux_tx_i  = 4'h9;
      send_frame({4'b1010, 4'h0, 4'h5, 20'hABCDE}, "R8 first frame");
      check("R2 pins", {12'd0, ext_drv_o}, 32'h000ABCDE);
      check("R3 oe on", {12'd0, ext_oe_o}, 32'h000FFFFF);
      check("R4 aux", {28'd0, aux_rx_o}, 32'h5);

      // R5: reserved bits set
      send_frame({4'b1010, 4'hF, 4'hA, 20'h0F0F0}, "R7 frame");
      check("R5 pins", {12'd0, ext_drv_o}, 32'h000F0F0F0 & 32'h000FFFFF);
      check("R5 oe", {12'd0, ext_oe_o}, 32'h000FFFFF);
      check("R5 aux", {28'd0, aux_rx_o}, 32'hA);

      // R6 / R9: a boundary that latches and loads at once, inputs changed mid frame
      send_bits({4'b1010, 4'h0, 4'h3, 20'h55555}, 0, 15);
      ext_smp_i = 20'hFEDCB;
      aux_tx_i  = 4'h6;
      repeat (2) @(negedge clk);
      check("R6 pins mid frame", {12'd0, ext_drv_o}, 32'h000F0F0);
      check("R6 aux mid frame", {28'd0, aux_rx_o}, 32'hA);
      send_bits({4'b1010, 4'h0, 4'h3, 20'h55555}, 16, 31);
      frame_done("R9 frame in flight");
      check("R6 pins after", {12'd0, ext_drv_o}, 32'h00055555);
      check("R4 aux after", {28'd0, aux_rx_o}, 32'h3);

      // R3: wrong codes release the pins
      send_frame({4'b0101, 4'h0, 4'hC, 20'h33333}, "R7 new sample");
      check("R3 oe off 0101", {12'd0, ext_oe_o}, 32'd0);
      check("R3 aux off 0101", {28'd0, aux_rx_o}, 32'd0);
      send_frame({4'b1011, 4'h0, 4'hC, 20'h33333}, "R7 repeat");
      check("R3 oe off 1011", {12'd0, ext_oe_o}, 32'd0);
      send_frame({4'b1010, 4'h0, 4'hC, 20'h33333}, "R7 repeat 2");
      check("R3 oe back on", {12'd0, ext_oe_o}, 32'h000FFFFF);
      check("R2 pins back", {12'd0, ext_drv_o}, 32'h00033333);
      check("R4 aux back", {28'd0, aux_rx_o}, 32'hC);

      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule